// File: doc/BRIEF.md
# Double-Buffered DAC Code Register Front End

This block is the digital side of a three-channel 10-bit digital-to-analog converter. It sits on a byte-wide register bus. Each channel stages its code in two registers: a high register with the top two bits and a low register with the bottom eight. Software writes the high register first and then the low register. The staged code reaches the converter only when the low-register write carries the commit (VALID) strobe. Until that commit, the converter keeps using the code it already has, even while software rewrites the staging registers.

Each channel also has a control register with two bits. The output-enable bit controls the tri-state pad model. The reference-enable bit controls standby. The block presents the following per channel:
- the active code;
- the two control bits;
- a combined drive flag, set only when both control bits are 1;
- a one-cycle update pulse on each commit.

Registers read back over the same bus.

Top module: `dac_code_frontend`

## Requirements
- R1: After reset, all staging and active codes are 0 and both control bits of every channel are 0. As a result, dac_drive and dac_update are 0 and every mapped register reads 0.
- R2: The high register keeps only bus_wdata[1:0] and reads back zero-extended. The low register keeps all 8 bits and reads them back. The commit strobe is never read back.
- R3: Channel n occupies bus addresses 4n to 4n+3. The offsets are: 0 for the high register, 1 for the low register with commit, and 2 for the control register.
- R4: A low-register write with bus_commit=1 loads the active code with {high register, bus_wdata}. The new code appears on dac_code after the same clock edge.
- R5: The active code does not change on writes without bus_commit. It also does not change on a commit that targets a high or control register.
- R6: Each commit raises dac_update for that channel for exactly one cycle, in the cycle the new code first appears.
- R7: In the control register, bit 0 is output-enable (dac_oe) and bit 1 is reference-enable (dac_refen). dac_drive is 1 only when both bits are 1.
- R8: Offset 3 of each block and addresses at 4*NUM_CH or above are unmapped. Writes to them change no register and no output, and reads of them return 0.
- R9: Channels are independent. A write to one channel leaves the code and control of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_commit | input | 1 | Commit (VALID) strobe, bit 8 of a low-register write |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| dac_code | output | NUM_CH*CODE_W | Active codes, channel n at bits [n*CODE_W +: CODE_W] |
| dac_oe | output | NUM_CH | Output-enable per channel (0 = high impedance) |
| dac_refen | output | NUM_CH | Reference-enable per channel (0 = standby) |
| dac_drive | output | NUM_CH | Channel drives a valid level (oe and refen both 1) |
| dac_update | output | NUM_CH | One-cycle pulse on each commit |

## Verification
The following results are due one clock edge after the write cycle:
- staging registers;
- control bits;
- the active code;
- the update pulse.

bus_rdata is combinational and is valid in the same cycle as bus_addr. The bench drives the bus at a falling edge. It checks registered outputs at the next falling edge, which is half a cycle after the edge that captured the write. One further falling edge later, it confirms that the update pulse has dropped. Each read is sampled in the middle of the cycle in which its address is held.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int REGS_PER_CH = 4;
    localparam int OFS_W       = 2;

    typedef enum logic [OFS_W-1:0] {
        REG_HI   = 2'd0,
        REG_LO   = 2'd1,
        REG_CTL  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/dacfe_decode.sv
module dacfe_decode
    import dacfe_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ch_hit,
    output reg_sel_e          sel,
    output logic              map_hit
);
    localparam int IDX_W = ADDR_W - OFS_W;

    logic [IDX_W-1:0] ch_idx;

    assign ch_idx = addr[ADDR_W-1:OFS_W];
    assign sel    = reg_sel_e'(addr[OFS_W-1:0]);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign ch_hit[i] = (int'(ch_idx) == i) && (sel != REG_NONE);
    end

    assign map_hit = |ch_hit;
endmodule

// File: rtl/dacfe_channel.sv
module dacfe_channel
    import dacfe_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  reg_sel_e          sel,
    input  logic              we,
    input  logic              commit,
    input  logic [DATA_W-1:0] wdata,
    output logic [CODE_W-1:0] code,
    output logic              oe,
    output logic              refen,
    output logic              drive,
    output logic              update,
    output logic [DATA_W-1:0] rdata
);
    localparam int HI_W = CODE_W - DATA_W;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [DATA_W-1:0] lo;
        logic [CODE_W-1:0] active;
        logic              oe;
        logic              refen;
        logic              upd;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      commit_lo;

    assign commit_lo = we && hit && (sel == REG_LO) && commit;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (we && hit) begin
            case (sel)
                REG_HI:  st_d.hi = wdata[HI_W-1:0];
                REG_LO: begin
                    st_d.lo = wdata;
                    if (commit) begin
                        st_d.active = {st_q.hi, wdata};
                        st_d.upd    = 1'b1;
                    end
                end
                REG_CTL: begin
                    st_d.oe    = wdata[0];
                    st_d.refen = wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (sel)
                REG_HI:  rdata = {{(DATA_W-HI_W){1'b0}}, st_q.hi};
                REG_LO:  rdata = st_q.lo;
                REG_CTL: rdata = {{(DATA_W-2){1'b0}}, st_q.refen, st_q.oe};
                default: rdata = '0;
            endcase
        end
    end

    assign code   = st_q.active;
    assign oe     = st_q.oe;
    assign refen  = st_q.refen;
    assign drive  = st_q.oe & st_q.refen;
    assign update = st_q.upd;

    AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        commit_lo |=> code == {$past(st_q.hi), $past(wdata)}); // R4
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_lo |=> $stable(code)); // R5
    AST_UPDATE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        update |-> $past(commit_lo)); // R6
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && hit && sel == REG_CTL) |=> $stable(oe) && $stable(refen)); // R9
endmodule

// File: rtl/dac_code_frontend.sv
module dac_code_frontend
    import dacfe_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CODE_W = 10,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we,
    input  logic                     bus_commit,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH-1:0]        dac_oe,
    output logic [NUM_CH-1:0]        dac_refen,
    output logic [NUM_CH-1:0]        dac_drive,
    output logic [NUM_CH-1:0]        dac_update
);
    logic [NUM_CH-1:0] ch_hit;
    reg_sel_e          sel;
    logic              map_hit;
    logic [DATA_W-1:0] ch_rdata [NUM_CH];

    dacfe_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .ch_hit  (ch_hit),
        .sel     (sel),
        .map_hit (map_hit)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dacfe_channel #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (ch_hit[i]),
            .sel    (sel),
            .we     (bus_we),
            .commit (bus_commit),
            .wdata  (bus_wdata),
            .code   (dac_code[i*CODE_W +: CODE_W]),
            .oe     (dac_oe[i]),
            .refen  (dac_refen[i]),
            .drive  (dac_drive[i]),
            .update (dac_update[i]),
            .rdata  (ch_rdata[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) bus_rdata = bus_rdata | ch_rdata[i];
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !map_hit |-> bus_rdata == '0); // R8
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_hit)); // R3
    AST_DRIVE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_drive & ~(dac_oe & dac_refen)) == '0); // R7
    AST_UPDATE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dac_update) <= 1); // R6
endmodule

// File: tb/tb_dac_code_frontend.sv
module tb_dac_code_frontend;
    localparam int NUM_CH = 3;
    localparam int CODE_W = 10;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic bus_commit = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NUM_CH*CODE_W-1:0] dac_code;
    logic [NUM_CH-1:0] dac_oe, dac_refen, dac_drive, dac_update;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dac_code_frontend #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_commit(bus_commit),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dac_code(dac_code), .dac_oe(dac_oe), .dac_refen(dac_refen),
        .dac_drive(dac_drive), .dac_update(dac_update)
    );

    typedef struct packed {
        logic [3:0]  addr;
        logic [7:0]  data;
        logic        commit;
        logic [29:0] codes;   // {ch2, ch1, ch0}
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 8'h03, 1'b0, {10'h000, 10'h000, 10'h000}}, // R2 stage high only
        '{4'd1, 8'hFF, 1'b0, {10'h000, 10'h000, 10'h000}}, // R5 low without commit
        '{4'd1, 8'hFF, 1'b1, {10'h000, 10'h000, 10'h3FF}}, // R4 commit ch0
        '{4'd4, 8'h02, 1'b0, {10'h000, 10'h000, 10'h3FF}}, // R9 ch1 high
        '{4'd5, 8'h34, 1'b1, {10'h000, 10'h234, 10'h3FF}}, // R4 commit ch1
        '{4'd8, 8'h01, 1'b0, {10'h000, 10'h234, 10'h3FF}}, // R3 ch2 high
        '{4'd9, 8'h80, 1'b1, {10'h180, 10'h234, 10'h3FF}}, // R4 commit ch2
        '{4'd0, 8'h00, 1'b0, {10'h180, 10'h234, 10'h3FF}}, // R5 restage ch0
        '{4'd1, 8'h55, 1'b1, {10'h180, 10'h234, 10'h055}}, // R4 commit ch0
        '{4'd0, 8'h01, 1'b1, {10'h180, 10'h234, 10'h055}}  // R5 commit on high
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic c);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_commit = c;
        @(negedge clk);
        bus_we = 1'b0; bus_commit = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, 32'(bus_rdata), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 code in reset", 32'(dac_code), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 code", 32'(dac_code), 32'd0);
        check("R1 oe/refen", 32'({dac_oe, dac_refen}), 32'd0);
        check("R1 drive/update", 32'({dac_drive, dac_update}), 32'd0);
        for (int a = 0; a < 12; a++) rd_check("R1 readback", 4'(a), 8'h00);

        for (int v = 0; v < NV; v++) begin
            wr(VECS[v].addr, VECS[v].data, VECS[v].commit);
            check($sformatf("R4/R5 vector %0d", v), 32'(dac_code), 32'(VECS[v].codes));
        end

        // R2 readback widths
        rd_check("R2 ch1 high", 4'd4, 8'h02);
        rd_check("R2 ch1 low", 4'd5, 8'h34);
        rd_check("R2 ch0 high", 4'd0, 8'h01);
        wr(4'd8, 8'hFF, 1'b0);
        rd_check("R2 high keeps two bits", 4'd8, 8'h03);

        // R6 update pulse
        wr(4'd9, 8'h0F, 1'b1);
        check("R6 pulse", 32'(dac_update), 32'b100);
        check("R4 ch2 code", 32'(dac_code[20 +: 10]), 32'h30F);
        @(negedge clk);
        check("R6 pulse ends", 32'(dac_update), 32'b000);
        wr(4'd1, 8'h10, 1'b0);
        check("R6 no pulse without commit", 32'(dac_update), 32'b000);

        // R7 control
        wr(4'd6, 8'h01, 1'b0);
        check("R7 oe only", 32'({dac_oe, dac_refen, dac_drive}), 32'({3'b010, 3'b000, 3'b000}));
        wr(4'd6, 8'h03, 1'b0);
        check("R7 both", 32'({dac_oe, dac_refen, dac_drive}), 32'({3'b010, 3'b010, 3'b010}));
        wr(4'd10, 8'h02, 1'b0);
        check("R7 refen only ch2", 32'({dac_oe, dac_refen, dac_drive}), 32'({3'b010, 3'b110, 3'b010}));
        rd_check("R7 ctl readback", 4'd6, 8'h03);
        check("R9 codes after ctl writes", 32'(dac_code), 32'({10'h30F, 10'h234, 10'h055}));

        // R8 unmapped
        wr(4'd3, 8'hFF, 1'b1);
        wr(4'd12, 8'hFF, 1'b1);
        wr(4'd15, 8'hAA, 1'b0);
        check("R8 codes unchanged", 32'(dac_code), 32'({10'h30F, 10'h234, 10'h055}));
        check("R8 ctl unchanged", 32'({dac_oe, dac_refen}), 32'({3'b010, 3'b110}));
        rd_check("R8 read ofs3", 4'd3, 8'h00);
        rd_check("R8 read 12", 4'd12, 8'h00);
        rd_check("R8 read 15", 4'd15, 8'h00);
        rd_check("R8 low ch0 intact", 4'd1, 8'h10);

        // R1 reset again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", 32'({dac_code[1:0], dac_oe, dac_refen}), 32'd0);
        rd_check("R1 ch1 low cleared", 4'd5, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule